// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block performs two-operand integer operations at 8, 16 or 32 bits and produces a six-bit status word along with the result. The status word holds signed overflow, nibble carry, carry, sign, zero and parity. A caller presents an operation, a size, two operands and the present carry flag together with a valid strobe. At that clock edge the block registers the sized result and the new status word. On the next cycle it raises a one-cycle done pulse and a result write-enable.

Eight arithmetic and logic operations are selected by a 3-bit code. A separate increment/decrement request overrides that code. It uses a constant second operand of one and carries the incoming carry flag through unchanged. Compare updates the status exactly as subtract does but never replaces the held result. The carry-consuming operations read the carry input as it stands at the capturing edge. A caller that feeds the registered carry straight back can therefore issue them back to back.

Top module: `flag_alu`

## Requirements
- R1: While rst_n is low, and after reset until the first accepted operation, res_q, flags_q, res_we and done are all zero.
- R2: op_code selects 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare. size_sel 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. The result is reduced modulo the selected size, and its upper bits read zero.
- R3: flags_q bit positions are carry 0, parity 1, nibble carry 2, zero 3, sign 4 and overflow 5. Sign is the top bit of the sized result. Zero is set when the sized result is all zeros. Parity is set when the low result byte holds an even number of ones.
- R4: Add-with-carry adds carry_in to the sum. Subtract-with-borrow subtracts carry_in. Both use carry_in as sampled at the same edge that updates flags_q. Carry is the carry out of, or the borrow into, the selected size.
- R5: Nibble carry is the carry out of bit 3 for additions, or the borrow into bit 3 for subtractions, with any carry_in included.
- R6: Overflow for additions is set when both operands have the same sign and the result sign differs from it. For subtractions it is set when the operand signs differ and the result sign differs from the first operand.
- R7: And, or and xor clear overflow, carry and nibble carry.
- R8: Compare sets every flag as subtract does. It holds res_q unchanged and leaves res_we low.
- R9: When incdec_en is high, op_code is ignored. The block adds 1 (incdec_down low) or subtracts 1 (incdec_down high) and sets overflow, nibble carry, sign, zero and parity from that operation. Carry is set equal to carry_in.
- R10: One cycle after in_valid is high, done is high and res_we is high unless the operation was compare. In any cycle that follows a cycle with in_valid low, done and res_we are low, and res_q and flags_q keep their values.
- R11: Operand bits above the selected size have no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accepts the operation presented this cycle |
| op_code | input | 3 | Operation select |
| size_sel | input | 2 | Operand size select |
| incdec_en | input | 1 | Increment/decrement request, overrides op_code |
| incdec_down | input | 1 | With incdec_en: 0 increments, 1 decrements |
| opnd_a | input | 32 | First operand (destination value) |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Present carry flag |
| res_q | output | 32 | Registered sized result |
| res_we | output | 1 | Result write-enable pulse |
| flags_q | output | 6 | Registered status word |
| done | output | 1 | Completion pulse, one cycle after acceptance |

## Verification
The case that matters is a carry-consuming operation accepted in the very cycle that the previous operation's carry lands in flags_q. In that case the flag register update and the carry read happen at the same edge. The bench issues an 8-bit add that overflows, with in_valid held high. In the next cycle it issues an add-with-carry whose carry_in is taken from flags_q. It checks both the intermediate status word and the final sum, which must include that carry, and it checks that the carry of the second operation is clear. A compare accepted between writes shows that the status word updates while res_q holds.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_OR  = 3'd1,
    OP_ADC = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_SUB = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam int FLAG_N = 6;
  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  // Bit count selected by the size code, clamped to the datapath width.
  function automatic int size_bits(input logic [1:0] sel, input int data_w);
    int w;
    case (sel)
      2'd0:    w = 8;
      2'd1:    w = 16;
      default: w = 32;
    endcase
    return (w > data_w) ? data_w : w;
  endfunction

  // Set when the byte has an even count of ones.
  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/fa_arith.sv
module fa_arith #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] a_m,
  input  logic [DATA_W-1:0] b_m,
  input  logic              cin,
  input  logic              sub,
  input  logic [IDX_W-1:0]  width,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              aux
);
  logic [DATA_W:0] ext;
  logic [DATA_W:0] ext_sh;
  logic [DATA_W:0] cin_ext;
  logic [DATA_W-1:0] nib;

  always_comb begin
    cin_ext = {{DATA_W{1'b0}}, cin};
    if (sub) ext = {1'b0, a_m} - {1'b0, b_m} - cin_ext;
    else     ext = {1'b0, a_m} + {1'b0, b_m} + cin_ext;
    sum    = ext[DATA_W-1:0];
    ext_sh = ext >> width;
    cout   = ext_sh[0];
    nib    = a_m ^ b_m ^ ext[DATA_W-1:0];
    aux    = nib[4];
  end
endmodule

// File: rtl/fa_logic.sv
module fa_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_m,
  input  logic [DATA_W-1:0] b_m,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] res
);
  import flag_alu_pkg::*;

  always_comb begin
    case (alu_op_e'(op))
      OP_OR:   res = a_m | b_m;
      OP_AND:  res = a_m & b_m;
      default: res = a_m ^ b_m;
    endcase
  end
endmodule

// File: rtl/fa_flags.sv
module fa_flags #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] res_m,
  input  logic [DATA_W-1:0] a_m,
  input  logic [DATA_W-1:0] b_m,
  input  logic [IDX_W-1:0]  msb,
  input  logic              sub,
  input  logic              logic_op,
  input  logic              cout,
  input  logic              aux,
  input  logic              keep_cf,
  input  logic              carry_in,
  output logic [flag_alu_pkg::FLAG_N-1:0] flags
);
  import flag_alu_pkg::*;

  logic [DATA_W-1:0] r_sh, a_sh, b_sh;
  logic r_s, a_s, b_s, ovf;

  always_comb begin
    r_sh = res_m >> msb;
    a_sh = a_m >> msb;
    b_sh = b_m >> msb;
    r_s  = r_sh[0];
    a_s  = a_sh[0];
    b_s  = b_sh[0];
    if (sub) ovf = (a_s != b_s) && (r_s != a_s);
    else     ovf = (a_s == b_s) && (r_s != a_s);

    flags       = '0;
    flags[F_SF] = r_s;
    flags[F_ZF] = (res_m == '0);
    flags[F_PF] = even_ones(res_m[7:0]);
    flags[F_OF] = logic_op ? 1'b0 : ovf;
    flags[F_AF] = logic_op ? 1'b0 : aux;
    flags[F_CF] = logic_op ? 1'b0 : (keep_cf ? carry_in : cout);
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        size_sel,
  input  logic              incdec_en,
  input  logic              incdec_down,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res_q,
  output logic              res_we,
  output logic [5:0]        flags_q,
  output logic              done
);
  import flag_alu_pkg::*;

  localparam int IDX_W = $clog2(DATA_W + 1);

  alu_op_e           op;
  logic [IDX_W-1:0]  width_w, msb_w;
  logic [DATA_W-1:0] mask_w, a_m, b_m, b_eff;
  logic [DATA_W:0]   mask_ext;
  logic              is_logic_w, is_sub_w, cin_used_w, wr_en_w;
  logic [DATA_W-1:0] sum_w, logic_w, res_w;
  logic              cout_w, aux_w;
  logic [FLAG_N-1:0] new_flags_w;

  always_comb begin
    op         = alu_op_e'(op_code);
    width_w    = IDX_W'(size_bits(size_sel, DATA_W));
    msb_w      = width_w - 1'b1;
    mask_ext   = ({{DATA_W{1'b0}}, 1'b1} << width_w) - 1'b1;
    mask_w     = mask_ext[DATA_W-1:0];
    b_eff      = incdec_en ? {{(DATA_W-1){1'b0}}, 1'b1} : opnd_b;
    a_m        = opnd_a & mask_w;
    b_m        = b_eff & mask_w;
    is_logic_w = !incdec_en && (op == OP_OR || op == OP_AND || op == OP_XOR);
    is_sub_w   = incdec_en ? incdec_down
                           : (op == OP_SBB || op == OP_SUB || op == OP_CMP);
    cin_used_w = !incdec_en && (op == OP_ADC || op == OP_SBB) && carry_in;
    wr_en_w    = incdec_en || (op != OP_CMP);
  end

  fa_arith #(.DATA_W(DATA_W)) u_arith (
    .a_m   (a_m),
    .b_m   (b_m),
    .cin   (cin_used_w),
    .sub   (is_sub_w),
    .width (width_w),
    .sum   (sum_w),
    .cout  (cout_w),
    .aux   (aux_w)
  );

  fa_logic #(.DATA_W(DATA_W)) u_logic (
    .a_m (a_m),
    .b_m (b_m),
    .op  (op_code),
    .res (logic_w)
  );

  assign res_w = (is_logic_w ? logic_w : sum_w) & mask_w;

  fa_flags #(.DATA_W(DATA_W)) u_flags (
    .res_m    (res_w),
    .a_m      (a_m),
    .b_m      (b_m),
    .msb      (msb_w),
    .sub      (is_sub_w),
    .logic_op (is_logic_w),
    .cout     (cout_w),
    .aux      (aux_w),
    .keep_cf  (incdec_en),
    .carry_in (carry_in),
    .flags    (new_flags_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      res_we  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done   <= in_valid;
      res_we <= in_valid && wr_en_w;
      if (in_valid) flags_q <= new_flags_w;
      if (in_valid && wr_en_w) res_q <= res_w;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              incdec_en,
  input logic [2:0]        op_code,
  input logic              carry_in,
  input logic              wr_en,
  input logic [DATA_W-1:0] res_q,
  input logic              res_we,
  input logic [5:0]        flags_q,
  input logic              done
);
  import flag_alu_pkg::*;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && !res_we && $stable(flags_q) && $stable(res_q)));

  a_r10_we_follows_decode: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_we == $past(wr_en)));

  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !incdec_en && op_code == 3'd7) |=> (!res_we && $stable(res_q)));

  a_r7_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !incdec_en && (op_code == 3'd1 || op_code == 3'd4 || op_code == 3'd6))
    |=> (!flags_q[F_OF] && !flags_q[F_CF] && !flags_q[F_AF]));

  a_r9_cf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && incdec_en) |=> (flags_q[F_CF] == $past(carry_in)));

  a_r10_we_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> done);
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_flag_alu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .incdec_en (incdec_en),
  .op_code   (op_code),
  .carry_in  (carry_in),
  .wr_en     (wr_en_w),
  .res_q     (res_q),
  .res_we    (res_we),
  .flags_q   (flags_q),
  .done      (done)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {op[3], size[2], cin[1], a[32], b[32], exp_res[32], exp_flags[6], exp_we[1]}
  localparam logic [108:0] VEC [NVEC] = '{
    {3'd0, 2'd0, 1'b0, 32'h0000_007F, 32'h0000_0001, 32'h0000_0080, 6'h34, 1'b1}, // R6 add overflow, R5
    {3'd0, 2'd0, 1'b0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 6'h0F, 1'b1}, // R2 wrap, R3 zero/parity
    {3'd2, 2'd1, 1'b1, 32'h0000_1234, 32'h0000_0001, 32'h0000_1236, 6'h02, 1'b1}, // R4 adc
    {3'd3, 2'd0, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 6'h17, 1'b1}, // R4 sbb borrow
    {3'd4, 2'd2, 1'b1, 32'hF0F0_0000, 32'hFF00_0000, 32'hF000_0000, 6'h12, 1'b1}, // R7 and
    {3'd5, 2'd2, 1'b0, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 6'h26, 1'b1}, // R6 sub overflow
    {3'd6, 2'd1, 1'b0, 32'h0000_AAAA, 32'h0000_AAAA, 32'h0000_0000, 6'h0A, 1'b1}, // R7 xor
    {3'd7, 2'd0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_0000, 6'h15, 1'b0}, // R8 cmp
    {3'd1, 2'd0, 1'b1, 32'h1234_560F, 32'hABCD_EF30, 32'h0000_003F, 6'h02, 1'b1}, // R11 or, upper bits
    {3'd5, 2'd1, 1'b0, 32'hFFFF_0003, 32'h0000_0003, 32'h0000_0000, 6'h0A, 1'b1}  // R11 sub, upper bits
  };

  logic        clk, rst_n, in_valid, incdec_en, incdec_down, carry_in;
  logic [2:0]  op_code;
  logic [1:0]  size_sel;
  logic [31:0] opnd_a, opnd_b, res_q;
  logic        res_we, done;
  logic [5:0]  flags_q;
  int checks, errors;
  bit finished;

  flag_alu i_flag_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .size_sel(size_sel), .incdec_en(incdec_en), .incdec_down(incdec_down),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .res_q(res_q), .res_we(res_we), .flags_q(flags_q), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation for one cycle; returns at the negedge after capture.
  task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic cin, input logic id, input logic dn);
    @(negedge clk);
    op_code = op; size_sel = sz; opnd_a = a; opnd_b = b; carry_in = cin;
    incdec_en = id; incdec_down = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; size_sel = '0; opnd_a = '0;
    opnd_b = '0; carry_in = 1'b0; incdec_en = 1'b0; incdec_down = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset res", res_q, 32'h0);
    check("R1 reset flags", {26'h0, flags_q}, 32'h0);
    check("R1 reset done/we", {30'h0, done, res_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {26'h0, flags_q}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      prev = res_q;
      issue(VEC[i][108:106], VEC[i][105:104], VEC[i][102:71], VEC[i][70:39],
            VEC[i][103], 1'b0, 1'b0);
      check($sformatf("R2/R3 vec%0d result", i), res_q, VEC[i][0] ? VEC[i][38:7] : prev);
      check($sformatf("R3 vec%0d flags", i), {26'h0, flags_q}, {26'h0, VEC[i][6:1]});
      check($sformatf("R10 vec%0d we", i), {31'h0, res_we}, {31'h0, VEC[i][0]});
      check($sformatf("R10 vec%0d done", i), {31'h0, done}, 32'h1);
    end

    // R10: idle cycle drops pulses and holds state
    prev = res_q;
    @(negedge clk);
    check("R10 done drops", {30'h0, done, res_we}, 32'h0);
    check("R10 result held", res_q, prev);
    check("R10 flags held", {26'h0, flags_q}, 32'h0A);

    // R9: increment, op_code set to compare must be ignored; CF follows carry_in
    issue(3'd7, 2'd0, 32'h0000_007F, 32'h0000_0055, 1'b1, 1'b1, 1'b0);
    check("R9 inc result", res_q, 32'h0000_0080);
    check("R9 inc flags", {26'h0, flags_q}, 32'h35);
    check("R9 inc writes", {31'h0, res_we}, 32'h1);
    issue(3'd0, 2'd0, 32'h0000_0000, 32'h0000_0099, 1'b0, 1'b1, 1'b1);
    check("R9 dec result", res_q, 32'h0000_00FF);
    check("R9 dec flags", {26'h0, flags_q}, 32'h16);

    // R4: back-to-back, carry fed from flags_q captured at the same edge
    @(negedge clk);
    op_code = 3'd0; size_sel = 2'd0; opnd_a = 32'hFF; opnd_b = 32'h01;
    carry_in = 1'b0; incdec_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R4 first flags", {26'h0, flags_q}, 32'h0F);
    op_code = 3'd2; opnd_a = 32'h10; opnd_b = 32'h20; carry_in = flags_q[0];
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 chained adc result", res_q, 32'h0000_0031);
    check("R4 chained adc flags", {26'h0, flags_q}, 32'h00);
    check("R10 chained done", {31'h0, done}, 32'h1);

    // R8: compare between writes keeps result, updates flags
    issue(3'd7, 2'd2, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, 1'b0);
    check("R8 cmp keeps result", res_q, 32'h0000_0031);
    check("R8 cmp flags", {26'h0, flags_q}, 32'h0A);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", {res_q[25:0], flags_q}, 32'h0);
    rst_n = 1'b1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule